// File: doc/BRIEF.md
# Packed Pixel Unpacker with Channel Swap

This block sits behind a framebuffer fetch engine and turns a stream of 32-bit memory words into ARGB pixels, one 32-bit pixel per handshake. The pixels can be stored in seven packed layouts: two 32-bit formats, one 24-bit format and four 16-bit formats. Colour fields narrower than eight bits are widened by copying their top bits into the freed low bits. A 24-bit pixel may span two memory words. To handle this, incoming bytes go into an eight-byte staging register, and each accepted pixel removes its bytes from the bottom of that register.

Three configuration inputs are sampled only on a frame-start pulse: a format code, a red/blue swap bit and an opaque flag. With the swap bit clear, the colour field stored highest in memory becomes blue. This is the reverse of the naming order. Setting the swap bit restores the conventional mapping. Alpha comes from the pixel only for formats that carry it, and the opaque flag can force it to 0xFF even then. The fetch side is expected to supply word-aligned data in which each line holds pixels-per-line times bytes-per-pixel bytes, so the unpacker does not skip or pad any bytes between pixels.

Top module: `pixel_unpacker`

## Requirements
- R1: During and after reset `pixValid` is 0 and `inReady` is 1. Until the first frame start the active settings are format code 0, swap 0 and opaque 0.
- R2: Format codes 0 (alpha plus 24-bit colour) and 1 (pad byte plus 24-bit colour) give one pixel per word. Bits 31:24 hold alpha or pad, bits 23:16 the high colour field, bits 15:8 green and bits 7:0 the low colour field. `pixOut` is alpha[31:24], red[23:16], green[15:8], blue[7:0].
- R3: With swap 0 the high colour field goes to blue and the low field to red. With swap 1 the high field goes to red and the low field to blue. Green and alpha are not affected.
- R4: The 16-bit formats give two pixels per word, bits 15:0 first. Code 6 stores high 5 bits at 15:11, green 6 bits at 10:5 and low 5 bits at 4:0. A 5-bit value v widens to {v, v[4:2]} and a 6-bit value to {v, v[5:4]}.
- R5: Codes 3 (with alpha) and 4 (pad nibble) store nibbles alpha/pad at 15:12, high at 11:8, green at 7:4 and low at 3:0. A nibble n widens to {n, n}.
- R6: Code 5 stores three 5-bit fields (high at 14:10, green at 9:5, low at 4:0). Bit 15 is an intensity bit that is discarded and never affects the output.
- R7: Code 2 packs 3-byte pixels (low field, green, high field from the lowest byte up). Four pixels come from every three words, with bytes taken least significant first and a pixel allowed to span two words.
- R8: Formats without alpha (codes 1, 2, 4, 5, 6) always output alpha 0xFF. With the opaque flag set, every format outputs alpha 0xFF.
- R9: Format, swap and opaque are latched only when `frameStart` is high. Changes at other times do not take effect until the next frame start.
- R10: A `frameStart` cycle drops any buffered partial pixel bytes and holds `inReady` and `pixValid` low, so a word offered in that cycle is not taken.
- R11: While `pixValid` is high and `pixReady` is low, `pixOut` and `pixValid` stay unchanged until the pixel is accepted.
- R12: The unused code 7 decodes exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Frame boundary pulse; latches settings, flushes staging |
| cfgFormat | input | 3 | Pixel format code |
| cfgSwap | input | 1 | Red/blue swap select |
| cfgOpaque | input | 1 | Force output alpha to 0xFF |
| inWord | input | 32 | Fetched memory word, first pixel in the low bytes |
| inValid | input | 1 | `inWord` is valid |
| inReady | output | 1 | Word accepted when high together with `inValid` |
| pixOut | output | 32 | Unpacked pixel, A/R/G/B from the top byte down |
| pixValid | output | 1 | `pixOut` holds a pixel |
| pixReady | input | 1 | Consumer takes the pixel |

## Verification
Every format code is driven with pseudo-random words and compared against a reference decode of each layout. The 32-bit and 16-bit runs show whether field positions, replication widths and pixel order within a word are right. Runs with nonzero pad and intensity bits show whether pad bits leak into alpha or colour. The 24-bit format is streamed across three- and six-word groups with periodic back-pressure, which shows whether word-spanning pixels are assembled correctly and whether stalled outputs stay stable. Settings changed mid-frame, and a frame start that interrupts a partial pixel, show whether configuration latching and the staging flush work.

// File: rtl/pu_pkg.sv
package pu_pkg;

  typedef enum logic [2:0] {
    PF_ARGB8888 = 3'd0,
    PF_XRGB8888 = 3'd1,
    PF_RGB888   = 3'd2,
    PF_ARGB4444 = 3'd3,
    PF_XRGB4444 = 3'd4,
    PF_XRGB1555 = 3'd5,
    PF_RGB565   = 3'd6,
    PF_RSVD     = 3'd7
  } pixFmt_e;

  typedef struct packed {
    pixFmt_e fmt;
    logic    swap;
    logic    opaque;
  } unpackCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       clearBuf;
    logic       pushWord;
    logic       popPix;
    logic [2:0] popBytes;
    logic [3:0] fillPos;
  } unpackStrb_t;

  function automatic logic [2:0] bytesPerPix(input pixFmt_e f);
    case (f)
      PF_ARGB8888, PF_XRGB8888, PF_RSVD: return 3'd4;
      PF_RGB888:                         return 3'd3;
      default:                           return 3'd2;
    endcase
  endfunction

  function automatic logic [7:0] rep4(input logic [3:0] v);
    return {v, v};
  endfunction

  function automatic logic [7:0] rep5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] rep6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

endpackage

// File: rtl/pu_expand.sv
module pu_expand
  import pu_pkg::*;
(
  input  logic [31:0] raw,
  input  unpackCfg_t  cfg,
  output logic [31:0] pixOut
);

  logic [7:0] alphaField;
  logic [7:0] hiField;
  logic [7:0] midField;
  logic [7:0] loField;
  logic       hasAlpha;
  logic [7:0] alphaOut;

  always_comb begin
    alphaField = 8'hFF;
    hasAlpha   = 1'b0;
    hiField    = raw[23:16];
    midField   = raw[15:8];
    loField    = raw[7:0];
    case (cfg.fmt)
      PF_ARGB8888, PF_RSVD: begin
        alphaField = raw[31:24];
        hasAlpha   = 1'b1;
      end
      PF_XRGB8888, PF_RGB888: begin
        hasAlpha = 1'b0;
      end
      PF_ARGB4444, PF_XRGB4444: begin
        alphaField = rep4(raw[15:12]);
        hasAlpha   = (cfg.fmt == PF_ARGB4444);
        hiField    = rep4(raw[11:8]);
        midField   = rep4(raw[7:4]);
        loField    = rep4(raw[3:0]);
      end
      PF_XRGB1555: begin
        hiField  = rep5(raw[14:10]);
        midField = rep5(raw[9:5]);
        loField  = rep5(raw[4:0]);
      end
      default: begin
        hiField  = rep5(raw[15:11]);
        midField = rep6(raw[10:5]);
        loField  = rep5(raw[4:0]);
      end
    endcase
    alphaOut = (cfg.opaque || !hasAlpha) ? 8'hFF : alphaField;
    if (cfg.swap)
      pixOut = {alphaOut, hiField, midField, loField};
    else
      pixOut = {alphaOut, loField, midField, hiField};
  end

endmodule

// File: rtl/pu_ctrl.sv
module pu_ctrl
  import pu_pkg::*;
#(
  parameter int WORD_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frameStart,
  input  logic [2:0]  cfgFormat,
  input  logic        cfgSwap,
  input  logic        cfgOpaque,
  input  logic        inValid,
  output logic        inReady,
  input  logic        pixReady,
  output logic        pixValid,
  output unpackCfg_t  cfgAct,
  output unpackStrb_t strb
);

  localparam int BUF_BYTES = 2 * WORD_BYTES;
  localparam int CNT_W     = $clog2(BUF_BYTES + 1);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntAfterPop;
  logic [CNT_W-1:0] bppW;
  logic [2:0]       bpp;

  assign bpp  = bytesPerPix(cfgAct.fmt);
  assign bppW = CNT_W'(bpp);

  always_comb begin
    pixValid      = !frameStart && (cntQ >= bppW);
    inReady       = !frameStart && (cntQ <= CNT_W'(WORD_BYTES));
    strb.clearBuf = frameStart;
    strb.popPix   = pixValid && pixReady;
    strb.pushWord = inValid && inReady;
    strb.popBytes = bpp;
    cntAfterPop   = cntQ - (strb.popPix ? bppW : '0);
    strb.fillPos  = 4'(cntAfterPop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ   <= '0;
      cfgAct <= '{fmt: PF_ARGB8888, swap: 1'b0, opaque: 1'b0};
    end else if (frameStart) begin
      cntQ   <= '0;
      cfgAct <= '{fmt: pixFmt_e'(cfgFormat), swap: cfgSwap, opaque: cfgOpaque};
    end else begin
      cntQ <= cntAfterPop + (strb.pushWord ? CNT_W'(WORD_BYTES) : '0);
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pushWord |-> (int'(cntAfterPop) + WORD_BYTES <= BUF_BYTES));

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cntQ) <= BUF_BYTES);

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frameStart |=> $stable(cfgAct));

  assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |=> !pixValid);

endmodule

// File: rtl/pu_datapath.sv
module pu_datapath
  import pu_pkg::*;
#(
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  unpackStrb_t             strb,
  input  unpackCfg_t              cfg,
  input  logic [8*WORD_BYTES-1:0] inWord,
  output logic [31:0]             pixOut
);

  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int BUF_W  = 2 * WORD_W;

  logic [BUF_W-1:0] bufQ;
  logic [BUF_W-1:0] shifted;
  logic [BUF_W-1:0] wordExt;

  always_comb begin
    shifted = strb.popPix ? (bufQ >> {strb.popBytes, 3'b000}) : bufQ;
    wordExt = BUF_W'(inWord) << {strb.fillPos, 3'b000};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bufQ <= '0;
    else if (strb.clearBuf)
      bufQ <= '0;
    else
      bufQ <= shifted | (strb.pushWord ? wordExt : '0);
  end

  pu_expand u_expand (
    .raw   (bufQ[31:0]),
    .cfg   (cfg),
    .pixOut(pixOut)
  );

  assert_opaque_alpha_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.opaque |-> (pixOut[31:24] == 8'hFF));

  assert_noalpha_fmt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.fmt inside {PF_XRGB8888, PF_RGB888, PF_XRGB4444, PF_XRGB1555, PF_RGB565})
      |-> (pixOut[31:24] == 8'hFF));

endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
  import pu_pkg::*;
#(
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frameStart,
  input  logic [2:0]              cfgFormat,
  input  logic                    cfgSwap,
  input  logic                    cfgOpaque,
  input  logic [8*WORD_BYTES-1:0] inWord,
  input  logic                    inValid,
  output logic                    inReady,
  output logic [31:0]             pixOut,
  output logic                    pixValid,
  input  logic                    pixReady
);

  unpackCfg_t  cfgAct;
  unpackStrb_t strb;

  pu_ctrl #(.WORD_BYTES(WORD_BYTES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .frameStart(frameStart),
    .cfgFormat (cfgFormat),
    .cfgSwap   (cfgSwap),
    .cfgOpaque (cfgOpaque),
    .inValid   (inValid),
    .inReady   (inReady),
    .pixReady  (pixReady),
    .pixValid  (pixValid),
    .cfgAct    (cfgAct),
    .strb      (strb)
  );

  pu_datapath #(.WORD_BYTES(WORD_BYTES)) u_datapath (
    .clk   (clk),
    .rst_n (rst_n),
    .strb  (strb),
    .cfg   (cfgAct),
    .inWord(inWord),
    .pixOut(pixOut)
  );

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pixValid && !pixReady && !frameStart)
      |=> (frameStart || (pixValid && $stable(pixOut))));

endmodule

// File: tb/test_pixel_unpacker.sv
`timescale 1ns/1ps
module test_pixel_unpacker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frameStart;
  logic [2:0]  cfgFormat;
  logic        cfgSwap;
  logic        cfgOpaque;
  logic [31:0] inWord;
  logic        inValid;
  logic        inReady;
  logic [31:0] pixOut;
  logic        pixValid;
  logic        pixReady;

  int checks = 0;
  int errors = 0;
  logic [31:0] wArr [0:11];

  always #2.5 clk = ~clk;

  pixel_unpacker i_pixel_unpacker (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart),
    .cfgFormat(cfgFormat), .cfgSwap(cfgSwap), .cfgOpaque(cfgOpaque),
    .inWord(inWord), .inValid(inValid), .inReady(inReady),
    .pixOut(pixOut), .pixValid(pixValid), .pixReady(pixReady)
  );

  function automatic int modelBpp(int fmt);
    if (fmt == 0 || fmt == 1 || fmt == 7) return 4;
    if (fmt == 2) return 3;
    return 2;
  endfunction

  function automatic logic [7:0] x4(logic [31:0] v);
    return 8'(v * 17);
  endfunction

  function automatic logic [7:0] x5(logic [31:0] v);
    return 8'((v << 3) | (v >> 2));
  endfunction

  function automatic logic [7:0] x6(logic [31:0] v);
    return 8'((v << 2) | (v >> 4));
  endfunction

  function automatic logic [31:0] modelPix(int fmt, bit swp, bit opq, logic [31:0] raw);
    logic [7:0] a, hi, md, lo;
    bit hasA;
    hasA = 0;
    a = 8'hFF;
    if (modelBpp(fmt) >= 3) begin
      hi = raw[23:16]; md = raw[15:8]; lo = raw[7:0];
      if (fmt != 2) a = raw[31:24];
      hasA = (fmt == 0 || fmt == 7);
    end else if (fmt == 3 || fmt == 4) begin
      a  = x4((raw >> 12) & 15);
      hi = x4((raw >> 8) & 15);
      md = x4((raw >> 4) & 15);
      lo = x4(raw & 15);
      hasA = (fmt == 3);
    end else if (fmt == 5) begin
      hi = x5((raw >> 10) & 31);
      md = x5((raw >> 5) & 31);
      lo = x5(raw & 31);
    end else begin
      hi = x5((raw >> 11) & 31);
      md = x6((raw >> 5) & 63);
      lo = x5(raw & 31);
    end
    if (opq || !hasA) a = 8'hFF;
    return swp ? {a, hi, md, lo} : {a, lo, md, hi};
  endfunction

  task automatic checkEq(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic fillWords(int seed);
    for (int i = 0; i < 12; i++) begin
      logic [31:0] k;
      k = 32'(i + 1 + seed);
      wArr[i] = (k * 32'h9E3779B9) ^ {4{8'(seed * 37)}};
    end
  endtask

  task automatic startFrame(int fmt, bit swp, bit opq);
    @(negedge clk);
    cfgFormat  = 3'(fmt);
    cfgSwap    = swp;
    cfgOpaque  = opq;
    frameStart = 1'b1;
    inValid    = 1'b1;
    inWord     = 32'hDEADBEEF;
    #1;
    checkEq("R10", "inReady during frameStart", {31'd0, inReady}, 32'd0);
    checkEq("R10", "pixValid during frameStart", {31'd0, pixValid}, 32'd0);
    @(negedge clk);
    frameStart = 1'b0;
    inValid    = 1'b0;
  endtask

  // streams nw words and checks every pixel; stallMod>0 stalls each stallMod-th cycle
  task automatic runStream(string tag, int fmt, bit swp, bit opq, int nw, int stallMod);
    int bpp, nPix, wi, pi, cyc;
    bit holdPending;
    logic [31:0] heldVal, raw;
    bpp = modelBpp(fmt);
    nPix = nw * 4 / bpp;
    wi = 0; pi = 0; cyc = 0;
    holdPending = 0;
    heldVal = '0;
    while (pi < nPix && cyc < 2000) begin
      @(negedge clk);
      inValid  = (wi < nw);
      inWord   = (wi < nw) ? wArr[wi] : 32'h0;
      pixReady = (stallMod == 0) || ((cyc % stallMod) != 0);
      #1;
      if (holdPending) begin
        checkEq("R11", "held pixValid", {31'd0, pixValid}, 32'd1);
        checkEq("R11", "held pixOut", pixOut, heldVal);
      end
      holdPending = 0;
      if (pixValid && !pixReady) begin
        holdPending = 1;
        heldVal = pixOut;
      end
      if (pixValid && pixReady) begin
        raw = '0;
        for (int j = 0; j < bpp; j++) begin
          int b;
          b = pi * bpp + j;
          raw[8*j +: 8] = wArr[b / 4][8*(b % 4) +: 8];
        end
        checkEq(tag, $sformatf("pixel %0d fmt %0d", pi, fmt), pixOut, modelPix(fmt, swp, opq, raw));
        pi++;
      end
      if (inValid && inReady) wi++;
      cyc++;
    end
    checkEq(tag, "pixel count", 32'(pi), 32'(nPix));
    @(negedge clk);
    inValid  = 1'b0;
    pixReady = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    frameStart = 1'b0; cfgFormat = 3'd0; cfgSwap = 1'b0; cfgOpaque = 1'b0;
    inWord = '0; inValid = 1'b0; pixReady = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    checkEq("R1", "pixValid in reset", {31'd0, pixValid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    checkEq("R1", "pixValid after reset", {31'd0, pixValid}, 32'd0);
    checkEq("R1", "inReady after reset", {31'd0, inReady}, 32'd1);
  endtask

  task automatic t_default_cfg();
    fillWords(1);
    // port settings differ from the reset defaults but no frame start was given
    cfgFormat = 3'd6; cfgSwap = 1'b1; cfgOpaque = 1'b1;
    runStream("R1", 0, 0, 0, 2, 0);
  endtask

  task automatic t_32bit();
    fillWords(2);
    startFrame(0, 0, 0);
    runStream("R2", 0, 0, 0, 4, 3);
    startFrame(0, 1, 0);
    runStream("R3", 0, 1, 0, 3, 0);
    startFrame(1, 0, 0);
    runStream("R8", 1, 0, 0, 3, 0);
    startFrame(0, 0, 1);
    runStream("R8", 0, 0, 1, 2, 0);
  endtask

  task automatic t_16bit();
    fillWords(3);
    startFrame(6, 0, 0);
    runStream("R4", 6, 0, 0, 3, 2);
    startFrame(6, 1, 0);
    runStream("R4", 6, 1, 0, 2, 0);
    startFrame(3, 0, 0);
    runStream("R5", 3, 0, 0, 3, 0);
    startFrame(4, 1, 0);
    runStream("R5", 4, 1, 0, 2, 0);
    fillWords(4);
    wArr[0] = 32'h8000_7FFF;
    wArr[1] = 32'hFFFF_0421;
    startFrame(5, 0, 0);
    runStream("R6", 5, 0, 0, 3, 0);
  endtask

  task automatic t_24bit();
    fillWords(5);
    startFrame(2, 0, 0);
    runStream("R7", 2, 0, 0, 3, 0);
    startFrame(2, 1, 0);
    runStream("R7", 2, 1, 0, 6, 3);
  endtask

  task automatic t_midchange();
    fillWords(6);
    startFrame(6, 0, 0);
    @(negedge clk);
    cfgFormat = 3'd0; cfgSwap = 1'b1; cfgOpaque = 1'b1;
    runStream("R9", 6, 0, 0, 2, 3);
  endtask

  task automatic t_flush();
    fillWords(7);
    startFrame(2, 0, 0);
    runStream("R10", 2, 0, 0, 1, 0);
    #1;
    checkEq("R10", "partial pixel not valid", {31'd0, pixValid}, 32'd0);
    fillWords(8);
    startFrame(0, 0, 0);
    runStream("R10", 0, 0, 0, 2, 0);
  endtask

  task automatic t_reserved();
    fillWords(9);
    startFrame(7, 1, 0);
    runStream("R12", 7, 1, 0, 2, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_default_cfg();
    t_32bit();
    t_16bit();
    t_24bit();
    t_midchange();
    t_flush();
    t_reserved();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule